// File: doc/BRIEF.md
# Sequential Flag-Offset Register Loader

This block stores the two programmable thresholds that a FIFO's flag logic compares against its fill level: the almost-empty offset n and the almost-full offset m. Each offset is held as a pair of 8-bit byte registers, a low byte and a high byte, which makes four byte registers in total. Software and system logic do not reach them through an address. A single 2-bit selector walks through them in a fixed, wrapping order. Each offset access moves the selector on by one. Between passes the selector keeps its position.

An active-low load strobe chooses between offset access and normal FIFO traffic. With the strobe low, a low write enable stores the data input into the selected register. With the strobe low and the write enable high, both read enables low return the selected register on a registered readback port. With the strobe high, a low write enable is passed on as an ordinary FIFO push. The two offsets are assembled continuously for the flag comparators. Each uses the full low byte plus only the high-byte bits that the configured depth needs.

Top module: `flag_offset_loader`

## Requirements
- R1: After reset the almost-empty offset and the almost-full offset both read 7, the readback is 0, the conflict flag is 0 and the selector points at the empty-offset low byte.
- R2: While load_n=0 and wen1_n=0, each rising edge stores din[7:0] into the selected register. Successive writes visit the registers in the order empty low, empty high, full low, full high.
- R3: The fifth offset access after the full-high byte wraps back to the empty-offset low byte.
- R4: When load_n is high the selector keeps its position. The next offset access continues with the register after the last one touched.
- R5: While load_n=0, wen1_n=1, ren1_n=0 and ren2_n=0, each rising edge loads rdata with {1'b0, selected register} and advances the selector, in the same order as R2.
- R6: With load_n=0, wen1_n=1 and fewer than both read enables low, no register, no selector position and no readback changes.
- R7: fifo_push is high exactly when load_n=1 and wen1_n=0, combinationally. While load_n=1 no offset register changes.
- R8: empty_off = {empty high byte[OFF_W-9:0], empty low byte} and full_off = {full high byte[OFF_W-9:0], full low byte}. High-byte bits above that width do not reach the outputs but still read back through rdata.
- R9: If an offset write and an offset read are requested in the same cycle, only the write takes effect: the selector advances once and rdata holds. seq_err is then set and stays set until reset.
- R10: rdata holds its value on every edge without an offset read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low offset access strobe |
| wen1_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| din | input | DATA_W (9) | Data input; bits 7:0 go into offset registers |
| rdata | output | DATA_W (9) | Registered readback of the selected register |
| empty_off | output | OFF_W (10) | Assembled almost-empty offset n |
| full_off | output | OFF_W (10) | Assembled almost-full offset m |
| fifo_push | output | 1 | Decoded ordinary FIFO write |
| seq_err | output | 1 | Sticky flag: offset read and write requested together |

## Verification
The assertions watch, on every cycle, the parts that do not depend on history. They check that the offsets stay put outside offset writes, that rdata holds outside offset reads and that the top readback bit stays zero. They also check that no push is decoded during a load, and that the conflict flag is sticky and rises only after a conflicting request. Only the bench scenarios can show the visiting order, the wrap after four accesses, the resumption after a partial pass and the default values after reset. These depend on the selector's hidden position and on which data was written in earlier cycles.

// File: rtl/flag_off_pkg.sv
package flag_off_pkg;

    // Position of the rotating selector; the order is behavioural.
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } sel_e;

    localparam int unsigned NUM_OFF_REGS = 4;

    // Decoded access for one cycle.
    typedef struct packed {
        logic off_wr;    // offset register write
        logic off_rd;    // offset register read
        logic push;      // ordinary FIFO write
        logic conflict;  // read and write requested together
    } access_t;

endpackage

// File: rtl/off_access_decode.sv
module off_access_decode
    import flag_off_pkg::*;
(
    input  logic    load_n,
    input  logic    wen1_n,
    input  logic    ren1_n,
    input  logic    ren2_n,
    output access_t acc
);

    logic both_ren;

    always_comb begin
        both_ren     = !ren1_n && !ren2_n;
        acc          = '0;
        // Offset write takes priority over offset read.
        acc.off_wr   = !load_n && !wen1_n;
        acc.off_rd   = !load_n &&  wen1_n && both_ren;
        acc.push     =  load_n && !wen1_n;
        acc.conflict = !load_n && !wen1_n && both_ren;
    end

endmodule

// File: rtl/off_selector.sv
module off_selector
    import flag_off_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output sel_e sel
);

    sel_e sel_d;
    sel_e sel_q;

    always_comb begin
        sel_d = sel_q;
        if (advance) begin
            sel_d = sel_e'(sel_q + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_EMPTY_LO;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;

endmodule

// File: rtl/off_regfile.sv
module off_regfile
    import flag_off_pkg::*;
#(
    parameter int unsigned REG_W   = 8,
    parameter int unsigned OFF_W   = 10,
    parameter int unsigned DEF_OFF = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sel_e             sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_val,
    output logic [OFF_W-1:0] empty_off,
    output logic [OFF_W-1:0] full_off
);

    localparam int unsigned HI_W = OFF_W - REG_W;
    localparam logic [2*REG_W-1:0] DEF_EXT = (2*REG_W)'(DEF_OFF);
    localparam logic [REG_W-1:0]   DEF_LO  = DEF_EXT[REG_W-1:0];
    localparam logic [REG_W-1:0]   DEF_HI  = DEF_EXT[2*REG_W-1:REG_W];

    logic [REG_W-1:0] regs_d [NUM_OFF_REGS];
    logic [REG_W-1:0] regs_q [NUM_OFF_REGS];

    always_comb begin
        for (int i = 0; i < NUM_OFF_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en) begin
            regs_d[sel] = wr_data;
        end
    end

    // Even index holds a low byte, odd index a high byte.
    for (genvar g = 0; g < NUM_OFF_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = (g % 2 == 0) ? DEF_LO : DEF_HI;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RST_VAL;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign rd_val    = regs_q[sel];
    assign empty_off = {regs_q[SEL_EMPTY_HI][HI_W-1:0], regs_q[SEL_EMPTY_LO]};
    assign full_off  = {regs_q[SEL_FULL_HI][HI_W-1:0],  regs_q[SEL_FULL_LO]};

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flag_off_pkg::*;
#(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned OFF_W   = 10,
    parameter int unsigned DEF_OFF = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic [OFF_W-1:0]  empty_off,
    output logic [OFF_W-1:0]  full_off,
    output logic              fifo_push,
    output logic              seq_err
);

    localparam int unsigned PAD_W = DATA_W - REG_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } top_state_t;

    access_t          acc;
    sel_e             sel;
    logic [REG_W-1:0] rd_val;
    logic [DATA_W-1:0] unused_din_hi;
    top_state_t       st_d;
    top_state_t       st_q;

    assign unused_din_hi = din;

    off_access_decode u_dec (
        .load_n (load_n),
        .wen1_n (wen1_n),
        .ren1_n (ren1_n),
        .ren2_n (ren2_n),
        .acc    (acc)
    );

    off_selector u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (acc.off_wr || acc.off_rd),
        .sel     (sel)
    );

    off_regfile #(
        .REG_W   (REG_W),
        .OFF_W   (OFF_W),
        .DEF_OFF (DEF_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc.off_wr),
        .sel       (sel),
        .wr_data   (din[REG_W-1:0]),
        .rd_val    (rd_val),
        .empty_off (empty_off),
        .full_off  (full_off)
    );

    always_comb begin
        st_d = st_q;
        if (acc.off_rd) begin
            st_d.rdata = {{PAD_W{1'b0}}, rd_val};
        end
        if (acc.conflict) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign seq_err   = st_q.err;
    assign fifo_push = acc.push;

endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned OFF_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [DATA_W-1:0] rdata,
    input logic [OFF_W-1:0]  empty_off,
    input logic [OFF_W-1:0]  full_off,
    input logic              fifo_push,
    input logic              seq_err
);

    a_r7_offsets_hold_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || wen1_n) |=> ($stable(empty_off) && $stable(full_off)));

    a_r7_no_push_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !fifo_push);

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(!load_n && wen1_n && !ren1_n && !ren2_n) |=> $stable(rdata));

    a_r5_readback_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[DATA_W-1]);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(!load_n && !wen1_n && !ren1_n && !ren2_n));

endmodule

bind flag_offset_loader flag_offset_loader_chk #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
) u_chk (.*);

// File: tb/flag_offset_loader_tb_top.sv
`timescale 1ns/1ps
module flag_offset_loader_tb_top;

    localparam int DATA_W = 9;
    localparam int OFF_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1;
    logic              wen1_n = 1'b1;
    logic              ren1_n = 1'b1;
    logic              ren2_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] rdata;
    logic [OFF_W-1:0]  empty_off;
    logic [OFF_W-1:0]  full_off;
    logic              fifo_push;
    logic              seq_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flag_offset_loader dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wen1_n    (wen1_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .din       (din),
        .rdata     (rdata),
        .empty_off (empty_off),
        .full_off  (full_off),
        .fifo_push (fifo_push),
        .seq_err   (seq_err)
    );

    typedef struct packed {
        logic              ld_n;
        logic              we_n;
        logic              r1_n;
        logic              r2_n;
        logic [DATA_W-1:0] d;
        logic              push;
        logic [DATA_W-1:0] rd;
        logic [OFF_W-1:0]  e;
        logic [OFF_W-1:0]  f;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b1,1'b1, 9'h025, 1'b0, 9'h000, 10'h025, 10'h007}, // R2 empty low
        '{1'b0,1'b0,1'b1,1'b1, 9'h1FE, 1'b0, 9'h000, 10'h225, 10'h007}, // R2 empty high, R8 truncation
        '{1'b1,1'b1,1'b1,1'b1, 9'h0AA, 1'b0, 9'h000, 10'h225, 10'h007}, // R4 idle, selector holds
        '{1'b1,1'b0,1'b1,1'b1, 9'h0BB, 1'b1, 9'h000, 10'h225, 10'h007}, // R7 push, no offset change
        '{1'b0,1'b0,1'b1,1'b1, 9'h040, 1'b0, 9'h000, 10'h225, 10'h040}, // R4 resumes at full low
        '{1'b0,1'b1,1'b0,1'b1, 9'h0CC, 1'b0, 9'h000, 10'h225, 10'h040}, // R6 one read enable only
        '{1'b0,1'b0,1'b1,1'b1, 9'h003, 1'b0, 9'h000, 10'h225, 10'h340}, // R2 full high
        '{1'b0,1'b0,1'b1,1'b1, 9'h011, 1'b0, 9'h000, 10'h211, 10'h340}, // R3 wrap to empty low
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h0FE, 10'h211, 10'h340}, // R5 read empty high
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h040, 10'h211, 10'h340}, // R5 read full low
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h003, 10'h211, 10'h340}, // R5 read full high
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h011, 10'h211, 10'h340}, // R3 R5 read wraps
        '{1'b1,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h011, 10'h211, 10'h340}, // R10 no read while load high
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 1'b0, 9'h0FE, 10'h211, 10'h340}  // R4 R5 resumes at empty high
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic we, input logic r1, input logic r2,
                         input logic [DATA_W-1:0] d);
        @(negedge clk);
        load_n = ld; wen1_n = we; ren1_n = r1; ren2_n = r2; din = d;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check_reset_state();
        check("R1 empty_off", 32'(empty_off), 32'h7);
        check("R1 full_off",  32'(full_off),  32'h7);
        check("R1 rdata",     32'(rdata),     32'h0);
        check("R1 seq_err",   32'(seq_err),   32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].ld_n, VECS[i].we_n, VECS[i].r1_n, VECS[i].r2_n, VECS[i].d);
            #1;
            check("R7 fifo_push", 32'(fifo_push), 32'(VECS[i].push));
            @(posedge clk);
            #1;
            check("R5 R10 rdata", 32'(rdata), 32'(VECS[i].rd));
            check("R2 R8 empty_off", 32'(empty_off), 32'(VECS[i].e));
            check("R2 R8 full_off", 32'(full_off), 32'(VECS[i].f));
        end

        // R9: simultaneous write and read, selector at full low
        drive(1'b0, 1'b0, 1'b0, 1'b0, 9'h05A);
        @(posedge clk); #1;
        check("R9 write wins full_off", 32'(full_off), 32'h35A);
        check("R9 rdata holds", 32'(rdata), 32'h0FE);
        check("R9 seq_err set", 32'(seq_err), 32'h1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        @(posedge clk); #1;
        check("R9 seq_err sticky", 32'(seq_err), 32'h1);
        // Selector advanced once: next read is full high
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        @(posedge clk); #1;
        check("R9 selector advanced once", 32'(rdata), 32'h003);

        // R6: load low, write enable high, reads off: nothing changes
        drive(1'b0, 1'b1, 1'b1, 1'b1, 9'h1FF);
        @(posedge clk); #1;
        check("R6 empty_off unchanged", 32'(empty_off), 32'h211);
        check("R6 rdata unchanged", 32'(rdata), 32'h003);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        @(posedge clk); #1;
        check("R6 selector unchanged", 32'(rdata), 32'h011);

        // R1: reset restores defaults and selector position
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h009);
        @(posedge clk); #1;
        check("R1 selector at empty low", 32'(empty_off), 32'h009);
        check("R1 full_off default kept", 32'(full_off), 32'h007);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        @(posedge clk); #1;

        finish_run();
    end

endmodule